// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps the exception side of a floating-point status word and the program-counter pair of the instruction stream that issues floating-point operations. When an operation finishes, its execution unit presents a 5-bit set of IEEE exception flags for one cycle. The recorder compares these flags with a software-written trap-enable mask and decides whether a trap is taken. It then rewrites the current-exception field, merges the flags into the accrued field when no trap is taken, records the trap type, and either steps the PC pair past the instruction or holds it so that trap delivery can resume at the faulting instruction.

When several enabled flags arrive together on a trapping operation, only the most severe one is kept. The order from most to least severe is invalid, overflow, underflow, divide-by-zero, inexact. A separate clear input wipes the exception history. Computing results and delivering the trap are done elsewhere.

Top module: `fp_exc_recorder`

## Requirements
- R1: After reset, `status_o` is all zeros, `trap_o` is 0, `pc_o` equals RESET_PC and `npc_o` equals RESET_PC+4.
- R2: A cycle with `mask_we_i` high loads `mask_wdata_i` into the enable field `status_o[27:23]`, and the new value shows on the next cycle. An operation in that same cycle is judged against the old mask.
- R3: `trap_o` is high for exactly the one cycle after an accepted operation, and only if `op_flags_i & enable field` is nonzero. Flag bits are invalid=bit4, overflow=bit3, underflow=bit2, divide-by-zero=bit1, inexact=bit0.
- R4: After a trapping operation, the current field `status_o[4:0]` holds one bit: the highest-numbered bit of `op_flags_i & enable field`.
- R5: After a non-trapping operation, the current field equals `op_flags_i` and the accrued field `status_o[9:5]` becomes its old value ORed with `op_flags_i`.
- R6: A trapping operation leaves the accrued field unchanged.
- R7: The trap-type field `status_o[16:14]` reads 3'b001 after a trapping operation and 3'b000 after a non-trapping operation.
- R8: After a non-trapping operation, `pc_o` takes the old `npc_o` and `npc_o` becomes the old `npc_o`+4, modulo 2^ADDR_W. After a trapping operation, both hold their values.
- R9: An operation reporting no flags clears the current field, leaves the accrued field unchanged, and steps the PC pair.
- R10: `clr_i` zeroes the current, accrued and trap-type fields on the next cycle, and keeps the mask and the PC pair. An operation presented in the same cycle is dropped: no trap, no PC step.
- R11: In a cycle with none of `op_valid_i`, `clr_i`, `mask_we_i`, no output changes. Bits 31:28, 22:17 and 13:10 of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | An operation completes this cycle |
| op_flags_i | input | 5 | IEEE exception flags of that operation |
| mask_we_i | input | 1 | Write strobe for the trap-enable mask |
| mask_wdata_i | input | 5 | New trap-enable mask |
| clr_i | input | 1 | Clear exception history |
| status_o | output | 32 | Status word (enable, trap type, accrued, current) |
| pc_o | output | ADDR_W | Address of the current instruction |
| npc_o | output | ADDR_W | Address of the next instruction |
| trap_o | output | 1 | One-cycle trap pulse |

## Verification
Every field is registered, so a wrong internal state shows at the ports on the cycle right after the operation that caused it. A wrong mask, a wrong narrowing, or a wrong accrued merge changes `status_o` or `trap_o` at that first cycle. A missed or extra PC step leaves `pc_o` and `npc_o` off by one instruction from then on. The bench models each cycle independently and compares every output on every cycle, idle cycles included. A field that drifts, or a history that a clear leaves partly in place, is therefore caught on the first cycle it differs.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int unsigned FLAG_W  = 5;
    localparam int unsigned TTYPE_W = 3;
    localparam int unsigned STAT_W  = 32;

    // flag bit positions (bit index is also severity rank)
    localparam int unsigned FLG_INEXACT = 0;
    localparam int unsigned FLG_DIVZERO = 1;
    localparam int unsigned FLG_UNDERFL = 2;
    localparam int unsigned FLG_OVERFL  = 3;
    localparam int unsigned FLG_INVALID = 4;

    // status word layout
    localparam int unsigned POS_CUR   = 0;
    localparam int unsigned POS_ACC   = 5;
    localparam int unsigned POS_TTYPE = 14;
    localparam int unsigned POS_MASK  = 23;

    localparam logic [TTYPE_W-1:0] TTYPE_NONE = 3'd0;
    localparam logic [TTYPE_W-1:0] TTYPE_IEEE = 3'd1;

    typedef struct packed {
        logic [FLAG_W-1:0]  mask;
        logic [TTYPE_W-1:0] ttype;
        logic [FLAG_W-1:0]  acc;
        logic [FLAG_W-1:0]  cur;
        logic               trap;
    } exc_state_t;

endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
    parameter int unsigned W = 5
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] pick_o
);
    // seen[i] is high when any request at index >= i is set
    logic [W:0] seen;
    assign seen[W] = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_rank
        assign seen[i]   = seen[i+1] | req_i[i];
        assign pick_o[i] = req_i[i] & ~seen[i+1];
    end
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
    import fpx_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] mask_i,
    output logic              trap_o,
    output logic [FLAG_W-1:0] cur_o
);
    logic [FLAG_W-1:0] enabled;
    logic [FLAG_W-1:0] single;

    assign enabled = flags_i & mask_i;

    fpx_prio_pick #(.W(FLAG_W)) u_pick (
        .req_i  (enabled),
        .pick_o (single)
    );

    always_comb begin
        trap_o = |enabled;
        cur_o  = trap_o ? single : flags_i;
    end
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
    parameter int unsigned ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] pc_d, pc_q, npc_d, npc_q;

    always_comb begin
        pc_d  = pc_q;
        npc_d = npc_q;
        if (adv_i) begin
            pc_d  = npc_q;
            npc_d = npc_q + STEP;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pc_q  <= RESET_PC;
            npc_q <= RESET_PC + STEP;
        end else begin
            pc_q  <= pc_d;
            npc_q <= npc_d;
        end
    end

    assign pc_o  = pc_q;
    assign npc_o = npc_q;
endmodule

// File: rtl/fp_exc_recorder.sv
module fp_exc_recorder
    import fpx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 op_valid_i,
    input  logic [FLAG_W-1:0]    op_flags_i,
    input  logic                 mask_we_i,
    input  logic [FLAG_W-1:0]    mask_wdata_i,
    input  logic                 clr_i,
    output logic [STAT_W-1:0]    status_o,
    output logic [ADDR_W-1:0]    pc_o,
    output logic [ADDR_W-1:0]    npc_o,
    output logic                 trap_o
);
    exc_state_t st_d, st_q;

    logic              eval_trap;
    logic [FLAG_W-1:0] eval_cur;
    logic              take_op;
    logic              pc_adv;

    fpx_trap_eval u_eval (
        .flags_i (op_flags_i),
        .mask_i  (st_q.mask),
        .trap_o  (eval_trap),
        .cur_o   (eval_cur)
    );

    assign take_op = op_valid_i & ~clr_i;
    assign pc_adv  = take_op & ~eval_trap;

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (clr_i) begin
            st_d.cur   = '0;
            st_d.acc   = '0;
            st_d.ttype = TTYPE_NONE;
        end else if (op_valid_i) begin
            st_d.cur   = eval_cur;
            st_d.ttype = eval_trap ? TTYPE_IEEE : TTYPE_NONE;
            st_d.trap  = eval_trap;
            if (!eval_trap) begin
                st_d.acc = st_q.acc | op_flags_i;
            end
        end
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fpx_pc_step #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (pc_adv),
        .pc_o   (pc_o),
        .npc_o  (npc_o)
    );

    always_comb begin
        status_o = '0;
        status_o[POS_CUR   +: FLAG_W]  = st_q.cur;
        status_o[POS_ACC   +: FLAG_W]  = st_q.acc;
        status_o[POS_TTYPE +: TTYPE_W] = st_q.ttype;
        status_o[POS_MASK  +: FLAG_W]  = st_q.mask;
    end

    assign trap_o = st_q.trap;
endmodule

// File: rtl/fpx_checker.sv
module fpx_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              op_valid_i,
    input logic [4:0]        op_flags_i,
    input logic              mask_we_i,
    input logic              clr_i,
    input logic [31:0]       status_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] npc_o,
    input logic              trap_o
);
    a_r3_trap_when_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !clr_i) |=> (trap_o == |($past(op_flags_i) & $past(status_o[27:23]))));

    a_r3_trap_needs_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(op_valid_i && !clr_i) |=> !trap_o);

    a_r4_single_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> ($countones(status_o[4:0]) == 1));

    a_r6_acc_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !clr_i) |=> (!trap_o || $stable(status_o[9:5])));

    a_r7_ttype: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> (status_o[16:14] == 3'b001));

    a_r8_pc_hold_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !clr_i) |=> (!trap_o || ($stable(pc_o) && $stable(npc_o))));

    a_r8_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && !clr_i) |=> (trap_o || (pc_o == $past(npc_o))));

    a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!op_valid_i && !clr_i && !mask_we_i) |=> ($stable(status_o) && $stable(pc_o)));

    a_r11_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[31:28] == 4'd0) && (status_o[22:17] == 6'd0) && (status_o[13:10] == 4'd0));
endmodule

bind fp_exc_recorder fpx_checker #(.ADDR_W(ADDR_W)) u_fpx_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_flags_i (op_flags_i),
    .mask_we_i  (mask_we_i),
    .clr_i      (clr_i),
    .status_o   (status_o),
    .pc_o       (pc_o),
    .npc_o      (npc_o),
    .trap_o     (trap_o)
);

// File: tb/fp_exc_recorder_bench.sv
`timescale 1ns/100ps
module fp_exc_recorder_bench;
    localparam int unsigned AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [4:0]    op_flags = '0;
    logic          mask_we = 1'b0;
    logic [4:0]    mask_wdata = '0;
    logic          clr = 1'b0;
    logic [31:0]   status;
    logic [AW-1:0] pc, npc;
    logic          trap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    fp_exc_recorder #(.ADDR_W(AW), .RESET_PC(32'h0000_1000)) u_fp_exc_recorder (
        .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_flags_i(op_flags),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .clr_i(clr),
        .status_o(status), .pc_o(pc), .npc_o(npc), .trap_o(trap)
    );

    typedef struct {
        logic [31:0]   st;
        logic [AW-1:0] pc;
        logic [AW-1:0] npc;
        logic          trap;
        string         tag;
    } exp_t;

    exp_t q[$];

    // reference model state
    logic [4:0]    m_mask = '0, m_acc = '0, m_cur = '0;
    logic [2:0]    m_tt = '0;
    logic [AW-1:0] m_pc = 32'h1000, m_npc = 32'h1004;

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] top_flag(input logic [4:0] f);
        if (f[4])      return 5'b10000;
        else if (f[3]) return 5'b01000;
        else if (f[2]) return 5'b00100;
        else if (f[1]) return 5'b00010;
        else           return 5'b00001;
    endfunction

    // driver: one cycle of stimulus, pushes the expected outputs
    task automatic step(input logic v, input logic [4:0] f, input logic we,
                        input logic [4:0] wm, input logic c, input string tag);
        exp_t e;
        logic t;
        @(negedge clk);
        op_valid = v; op_flags = f; mask_we = we; mask_wdata = wm; clr = c;
        t = 1'b0;
        if (c) begin
            m_cur = '0; m_acc = '0; m_tt = '0;
        end else if (v) begin
            t = |(f & m_mask);
            if (t) begin
                m_cur = top_flag(f & m_mask);
                m_tt  = 3'b001;
            end else begin
                m_cur = f;
                m_acc = m_acc | f;
                m_tt  = 3'b000;
                m_pc  = m_npc;
                m_npc = m_npc + 4;
            end
        end
        if (we) m_mask = wm;
        e.st   = {4'b0, m_mask, 6'b0, m_tt, 4'b0, m_acc, m_cur};
        e.pc   = m_pc;
        e.npc  = m_npc;
        e.trap = t;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // monitor: compares each cycle's result shortly after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " status"}, AW'(status), AW'(e.st));
                check({e.tag, " pc"},     pc,          e.pc);
                check({e.tag, " npc"},    npc,         e.npc);
                check({e.tag, " trap"},   AW'(trap),   AW'(e.trap));
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 status", AW'(status), '0);
        check("R1 pc", pc, 32'h1000);
        check("R1 npc", npc, 32'h1004);
        check("R1 trap", AW'(trap), '0);

        step(0, 5'b00000, 1, 5'b10100, 0, "R2 mask write");
        step(1, 5'b00001, 0, 5'b00000, 0, "R5 inexact no trap");
        step(1, 5'b10101, 0, 5'b00000, 0, "R4 trap invalid wins");
        step(1, 5'b00100, 0, 5'b00000, 0, "R6 trap underflow");
        step(1, 5'b00000, 0, 5'b00000, 0, "R9 no flags");
        step(1, 5'b01010, 0, 5'b00000, 0, "R5 merge accrued");
        step(0, 5'b11111, 0, 5'b00000, 0, "R11 idle");
        step(0, 5'b00000, 1, 5'b11111, 0, "R2 all enabled");
        step(1, 5'b01111, 0, 5'b00000, 0, "R4 overflow wins");
        step(1, 5'b00011, 0, 5'b00000, 0, "R4 divzero wins");
        step(1, 5'b00001, 0, 5'b00000, 0, "R7 inexact trap");
        step(1, 5'b10000, 1, 5'b00000, 0, "R2 op uses old mask");
        step(1, 5'b10000, 0, 5'b00000, 0, "R3 disabled no trap");
        step(1, 5'b11111, 0, 5'b00000, 0, "R8 step no trap");
        step(0, 5'b00000, 1, 5'b01000, 0, "R2 overflow only");
        step(1, 5'b01000, 1, 5'b01000, 1, "R10 clear drops op");
        step(1, 5'b01000, 0, 5'b00000, 0, "R7 trap after clear");
        step(1, 5'b00110, 0, 5'b00000, 0, "R7 no trap clears type");
        step(0, 5'b00000, 0, 5'b00000, 1, "R10 clear");
        step(0, 5'b00000, 0, 5'b00000, 0, "R11 idle end");
        step(0, 5'b00000, 0, 5'b00000, 0, "R11 idle end2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule